// File: doc/BRIEF.md
# Two-Region Chained DMA Address Sequencer

This block is the address and count engine of one DMA channel. Software describes two memory regions, A and B, each by a start address and a beat count. It then arms one or both of them. The sequencer walks the armed region one memory word per beat, stepping the address by four bytes and counting the beats down. When a region runs out, the sequencer moves on to the other region in the next cycle, as long as that region was armed in time. If it was not, the channel falls idle.

Each region has an armed bit and a done bit. A finished region gets its done bit set, loses its armed bit and raises a one-cycle interrupt. The `activeBuf` status output shows which region is in use. While one region runs, software is free to reprogram and re-arm the other. Writes aimed at the running region are dropped, so the transfer in progress cannot be corrupted. Work advances in device-sized bursts. A service request from the device, taken while no burst is open, buys a fixed number of beats. Register decoding and the data path sit outside this block.

Top module: `pp_dma_seq`

## Requirements
- R1: After reset the channel is idle (`chanIdle`=1), `armedOut` and `doneOut` are 0, `beatValid` and `irq` are 0, and region A is the first region to be chosen.
- R2: A pulse on `armReq` (bit 0 = A, bit 1 = B) sets that region's armed bit and clears its done bit on the next edge. The pulse is ignored when that region's count register is zero, and it is ignored when that region is the one running.
- R3: When idle, the channel starts the armed region that did not run last; if only the last-run region is armed, that one starts. The first beat can appear two cycles after the arm pulse.
- R4: The first beat of a region presents its programmed start address on `beatAddr`, and each following beat presents an address 4 higher.
- R5: A region produces exactly as many beats as its programmed count.
- R6: In the cycle after a region's final beat, `irq` is high for exactly one cycle, that region's done bit is set and its armed bit is clear.
- R7: If the other region is armed when a region completes, the other region becomes active at once, and with `beatReq` held high its first beat follows the previous region's final beat in the very next cycle.
- R8: If the other region is not armed when a region completes, the channel goes idle and issues no more beats.
- R9: Address and count writes (`cfgBufSel` 0 = A, 1 = B; `cfgIsCnt` 1 = count, 0 = address) to the running region are ignored. The same writes to the other region take effect.
- R10: A `beatReq` seen while no burst is open starts a burst of BURST_LEN beats (4 by default), one per cycle, whatever `beatReq` does afterwards. A burst is cut short when its region completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Register write strobe |
| cfgBufSel | input | 1 | Region written: 0 = A, 1 = B |
| cfgIsCnt | input | 1 | 1 writes the count, 0 writes the start address |
| cfgData | input | ADDR_W | Write data; the count uses the low CNT_W bits |
| armReq | input | 2 | Arm pulses, bit 0 = A, bit 1 = B |
| beatReq | input | 1 | Device service request |
| beatValid | output | 1 | A beat is issued this cycle |
| beatAddr | output | ADDR_W | Memory address of the current beat |
| activeBuf | output | 1 | Region in use (last used when idle) |
| chanIdle | output | 1 | Channel is not running |
| armedOut | output | 2 | Armed bits, bit 0 = A |
| doneOut | output | 2 | Done bits, bit 0 = A |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the inputs. `armReq` comes as a short pulse. A count is written at least one cycle before the arm that depends on it. `beatReq` only changes between clock edges. The bench keeps every write and arm in its own cycle, and it places each count write ahead of the arm pulse. It drives all inputs just after the rising edge and reads the outputs on the falling edge, so every recorded beat belongs to one defined cycle.

// File: rtl/pp_dma_seq_pkg.sv
`timescale 1ns/1ps
package pp_dma_seq_pkg;
  localparam int NUM_BUF = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic beat;   // one beat consumed this cycle
    logic sel;    // region in use
    logic busy;   // channel running
  } seqCtl_t;
endpackage

// File: rtl/pp_dma_seq_dp.sv
`timescale 1ns/1ps
module pp_dma_seq_dp
  import pp_dma_seq_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int CNT_W          = 16,
  parameter int BYTES_PER_BEAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cfgBufSel,
  input  logic              cfgIsCnt,
  input  logic [ADDR_W-1:0] cfgData,
  input  seqCtl_t           ctl,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              lastBeat,
  output logic [NUM_BUF-1:0] cntZero
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BYTES_PER_BEAT);
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

  logic [ADDR_W-1:0] addrArr [NUM_BUF];
  logic [CNT_W-1:0]  cntArr  [NUM_BUF];
  logic [CNT_W-1:0]  curCnt;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic [ADDR_W-1:0] addrQ;
    logic [CNT_W-1:0]  cntQ;
    logic              isActive;
    logic              wrHit;
    logic              step;

    assign isActive = ctl.busy && (ctl.sel == 1'(b));
    assign wrHit    = cfgWr && (cfgBufSel == 1'(b)) && !isActive;
    assign step     = ctl.beat && (ctl.sel == 1'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ <= '0;
        cntQ  <= '0;
      end else if (wrHit) begin
        if (cfgIsCnt) cntQ  <= cfgData[CNT_W-1:0];
        else          addrQ <= cfgData;
      end else if (step) begin
        addrQ <= addrQ + ADDR_STEP;
        cntQ  <= cntQ - CNT_ONE;
      end
    end

    assign addrArr[b] = addrQ;
    assign cntArr[b]  = cntQ;
    assign cntZero[b] = (cntQ == '0);
  end

  assign beatAddr = addrArr[ctl.sel];
  assign curCnt   = cntArr[ctl.sel];
  assign lastBeat = (curCnt == CNT_ONE);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.beat && !lastBeat |=> beatAddr == $past(beatAddr) + ADDR_STEP); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.beat && !lastBeat |=> curCnt == $past(curCnt) - CNT_ONE); // R5

  AST_WR_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr && cfgIsCnt && ctl.busy && (cfgBufSel == ctl.sel) && !ctl.beat
      |=> curCnt == $past(curCnt)); // R9
endmodule

// File: rtl/pp_dma_seq_ctrl.sv
`timescale 1ns/1ps
module pp_dma_seq_ctrl
  import pp_dma_seq_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUF-1:0] armReq,
  input  logic               beatReq,
  input  logic               lastBeat,
  input  logic [NUM_BUF-1:0] cntZero,
  output seqCtl_t            ctl,
  output logic               beatValid,
  output logic               activeBuf,
  output logic               chanIdle,
  output logic [NUM_BUF-1:0] armedOut,
  output logic [NUM_BUF-1:0] doneOut,
  output logic               irq
);
  localparam int BL_W = $clog2(BURST_LEN + 1);
  localparam logic [BL_W-1:0] BURST_RELOAD = BL_W'(BURST_LEN - 1);

  logic               running;
  logic               curBuf;
  logic [NUM_BUF-1:0] armedQ;
  logic [NUM_BUF-1:0] doneQ;
  logic [BL_W-1:0]    burstLeft;
  logic               irqQ;

  logic inBurst;
  logic beat;
  logic finish;
  logic otherBuf;

  assign inBurst  = (burstLeft != '0);
  assign beat     = running && (inBurst || beatReq);
  assign finish   = beat && lastBeat;
  assign otherBuf = ~curBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      curBuf    <= 1'b1;          // so that region A is chosen first
      armedQ    <= '0;
      doneQ     <= '0;
      burstLeft <= '0;
      irqQ      <= 1'b0;
    end else begin
      irqQ <= finish;
      for (int b = 0; b < NUM_BUF; b++) begin
        if (armReq[b] && !cntZero[b] && !(running && curBuf == 1'(b))) begin
          armedQ[b] <= 1'b1;
          doneQ[b]  <= 1'b0;
        end
      end
      if (finish) begin
        armedQ[curBuf] <= 1'b0;
        doneQ[curBuf]  <= 1'b1;
        burstLeft      <= '0;
        if (armedQ[otherBuf]) curBuf  <= otherBuf;
        else                  running <= 1'b0;
      end else if (beat) begin
        burstLeft <= inBurst ? burstLeft - BL_W'(1) : BURST_RELOAD;
      end
      if (!running) begin
        if (armedQ[otherBuf]) begin
          running <= 1'b1;
          curBuf  <= otherBuf;
        end else if (armedQ[curBuf]) begin
          running <= 1'b1;
        end
      end
    end
  end

  assign ctl.beat  = beat;
  assign ctl.sel   = curBuf;
  assign ctl.busy  = running;
  assign beatValid = beat;
  assign activeBuf = curBuf;
  assign chanIdle  = !running;
  assign armedOut  = armedQ;
  assign doneOut   = doneQ;
  assign irq       = irqQ;

  AST_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(beatValid && lastBeat)); // R6

  AST_DONE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> doneQ[$past(curBuf)]); // R6

  AST_HANDOVER: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && lastBeat && armedQ[otherBuf]
      |=> !chanIdle && (activeBuf != $past(activeBuf))); // R7

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && lastBeat && !armedQ[otherBuf] |=> chanIdle); // R8

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !beatReq |-> $past(beatValid)); // R10

  AST_ARM_ZERO_A: assert property (@(posedge clk) disable iff (!rstN)
    armReq[0] && cntZero[0] && !armedQ[0] |=> !armedQ[0]); // R2

  AST_ARM_ZERO_B: assert property (@(posedge clk) disable iff (!rstN)
    armReq[1] && cntZero[1] && !armedQ[1] |=> !armedQ[1]); // R2
endmodule

// File: rtl/pp_dma_seq.sv
`timescale 1ns/1ps
module pp_dma_seq
  import pp_dma_seq_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int CNT_W          = 16,
  parameter int BYTES_PER_BEAT = 4,
  parameter int BURST_LEN      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cfgBufSel,
  input  logic              cfgIsCnt,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [1:0]        armReq,
  input  logic              beatReq,
  output logic              beatValid,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              activeBuf,
  output logic              chanIdle,
  output logic [1:0]        armedOut,
  output logic [1:0]        doneOut,
  output logic              irq
);
  seqCtl_t            ctl;
  logic               lastBeat;
  logic [NUM_BUF-1:0] cntZero;

  pp_dma_seq_ctrl #(
    .BURST_LEN(BURST_LEN)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .armReq   (armReq),
    .beatReq  (beatReq),
    .lastBeat (lastBeat),
    .cntZero  (cntZero),
    .ctl      (ctl),
    .beatValid(beatValid),
    .activeBuf(activeBuf),
    .chanIdle (chanIdle),
    .armedOut (armedOut),
    .doneOut  (doneOut),
    .irq      (irq)
  );

  pp_dma_seq_dp #(
    .ADDR_W        (ADDR_W),
    .CNT_W         (CNT_W),
    .BYTES_PER_BEAT(BYTES_PER_BEAT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWr    (cfgWr),
    .cfgBufSel(cfgBufSel),
    .cfgIsCnt (cfgIsCnt),
    .cfgData  (cfgData),
    .ctl      (ctl),
    .beatAddr (beatAddr),
    .lastBeat (lastBeat),
    .cntZero  (cntZero)
  );
endmodule

// File: tb/pp_dma_seq_tb_top.sv
`timescale 1ns/1ps
module pp_dma_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic        cfgBufSel = 1'b0;
  logic        cfgIsCnt = 1'b0;
  logic [31:0] cfgData = '0;
  logic [1:0]  armReq = '0;
  logic        beatReq = 1'b0;
  logic        beatValid;
  logic [31:0] beatAddr;
  logic        activeBuf;
  logic        chanIdle;
  logic [1:0]  armedOut;
  logic [1:0]  doneOut;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int beatCnt = 0;
  int irqCnt = 0;
  logic [31:0] addrLog [64];
  int          cycLog  [64];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pp_dma_seq dut_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgBufSel(cfgBufSel),
    .cfgIsCnt(cfgIsCnt), .cfgData(cfgData), .armReq(armReq),
    .beatReq(beatReq), .beatValid(beatValid), .beatAddr(beatAddr),
    .activeBuf(activeBuf), .chanIdle(chanIdle), .armedOut(armedOut),
    .doneOut(doneOut), .irq(irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (beatValid && beatCnt < 64) begin
        addrLog[beatCnt] = beatAddr;
        cycLog[beatCnt]  = cyc;
      end
      if (beatValid) beatCnt = beatCnt + 1;
      if (irq) irqCnt = irqCnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearLog();
    @(negedge clk);
    beatCnt = 0;
    irqCnt  = 0;
  endtask

  task automatic cfgWrite(input bit sel, input bit isCnt, input logic [31:0] d);
    @(posedge clk); #1;
    cfgWr = 1'b1; cfgBufSel = sel; cfgIsCnt = isCnt; cfgData = d;
    @(posedge clk); #1;
    cfgWr = 1'b0;
  endtask

  task automatic arm(input logic [1:0] m);
    @(posedge clk); #1;
    armReq = m;
    @(posedge clk); #1;
    armReq = '0;
  endtask

  task automatic pulseReq();
    @(posedge clk); #1;
    beatReq = 1'b1;
    @(posedge clk); #1;
    beatReq = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (chanIdle && armedOut == 2'b00) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(chanIdle == 1'b1, "R1 idle", chanIdle, 1);
    check(armedOut == 2'b00 && doneOut == 2'b00, "R1 status", {armedOut, doneOut}, 0);
    check(!beatValid && !irq, "R1 outputs", {beatValid, irq}, 0);
  endtask

  // region A alone, after reset A is chosen first
  task automatic testSingle();
    cfgWrite(1'b0, 1'b0, 32'h1000);
    cfgWrite(1'b0, 1'b1, 32'd6);
    clearLog();
    beatReq = 1'b1;
    arm(2'b01);
    waitIdle();
    beatReq = 1'b0;
    check(beatCnt == 6, "R5 beat count A", beatCnt, 6);
    for (int i = 0; i < 6; i++)
      check(addrLog[i] == 32'h1000 + 4 * i, "R4 address step", addrLog[i], 32'h1000 + 4 * i);
    check(irqCnt == 1, "R6 irq one cycle", irqCnt, 1);
    check(doneOut == 2'b01 && armedOut == 2'b00, "R6 done set armed clear", {armedOut, doneOut}, 2'b01);
    check(chanIdle == 1'b1, "R8 idle after completion", chanIdle, 1);
  endtask

  // both armed: B starts since A ran last, then immediate hand-over to A
  task automatic testChain();
    cfgWrite(1'b0, 1'b0, 32'h2000);
    cfgWrite(1'b0, 1'b1, 32'd3);
    cfgWrite(1'b1, 1'b0, 32'h3000);
    cfgWrite(1'b1, 1'b1, 32'd5);
    clearLog();
    beatReq = 1'b1;
    arm(2'b11);
    @(negedge clk);
    check(doneOut[0] == 1'b0, "R2 arm clears done", doneOut[0], 0);
    waitIdle();
    beatReq = 1'b0;
    check(beatCnt == 8, "R5 chained beat count", beatCnt, 8);
    check(addrLog[0] == 32'h3000, "R3 other region first", addrLog[0], 32'h3000);
    check(addrLog[5] == 32'h2000, "R7 second region start", addrLog[5], 32'h2000);
    check(cycLog[5] == cycLog[4] + 1, "R7 no gap at hand-over", cycLog[5] - cycLog[4], 1);
    check(irqCnt == 2 && doneOut == 2'b11, "R6 both done", {irqCnt, doneOut}, {32'd2, 2'b11});
  endtask

  // writes to the running region are dropped, the idle one is reloaded
  task automatic testProtect();
    cfgWrite(1'b0, 1'b0, 32'h4000);
    cfgWrite(1'b0, 1'b1, 32'd8);
    clearLog();
    arm(2'b01);
    pulseReq();
    repeat (8) @(negedge clk);
    check(beatCnt == 4, "R10 one burst per request", beatCnt, 4);
    check(activeBuf == 1'b0 && !chanIdle, "R3 A active", {activeBuf, chanIdle}, 0);
    cfgWrite(1'b0, 1'b0, 32'h9000);
    cfgWrite(1'b0, 1'b1, 32'd1);
    cfgWrite(1'b1, 1'b0, 32'h5000);
    cfgWrite(1'b1, 1'b1, 32'd2);
    arm(2'b10);
    @(negedge clk);
    check(armedOut == 2'b11, "R2 arm idle region while running", armedOut, 2'b11);
    beatReq = 1'b1;
    waitIdle();
    beatReq = 1'b0;
    check(beatCnt == 10, "R9 active count kept", beatCnt, 10);
    check(addrLog[4] == 32'h4010, "R9 active address kept", addrLog[4], 32'h4010);
    check(addrLog[8] == 32'h5000 && addrLog[9] == 32'h5004, "R9 inactive reload", addrLog[8], 32'h5000);
  endtask

  // burst cut short at region end
  task automatic testBurstTrunc();
    cfgWrite(1'b0, 1'b0, 32'h6000);
    cfgWrite(1'b0, 1'b1, 32'd6);
    clearLog();
    arm(2'b01);
    pulseReq();
    repeat (8) @(negedge clk);
    check(beatCnt == 4, "R10 first burst", beatCnt, 4);
    pulseReq();
    repeat (8) @(negedge clk);
    check(beatCnt == 6, "R10 truncated burst", beatCnt, 6);
    check(chanIdle && irqCnt == 1, "R8 idle after truncated burst", {chanIdle, irqCnt}, 1);
    check(addrLog[5] == 32'h6014, "R4 last address", addrLog[5], 32'h6014);
  endtask

  // arming a region with a zero count is ignored
  task automatic testZeroArm();
    cfgWrite(1'b1, 1'b1, 32'd0);
    clearLog();
    beatReq = 1'b1;
    arm(2'b10);
    repeat (6) @(negedge clk);
    beatReq = 1'b0;
    check(armedOut[1] == 1'b0, "R2 zero count arm ignored", armedOut[1], 0);
    check(beatCnt == 0 && chanIdle, "R2 no beats from zero count", beatCnt, 0);
    check(doneOut[1] == 1'b1, "R2 done kept on ignored arm", doneOut[1], 1);
  endtask

  initial begin
    testReset();
    testSingle();
    testChain();
    testProtect();
    testBurstTrunc();
    testZeroArm();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule